// File: doc/BRIEF.md
# Configurable Byte-Wide GPIO Port

This block is one byte-wide general-purpose I/O port on a small controller's data bus. Every pin has one data bit and one configuration bit. Together the two bits choose the pin's mode: a floating input, an input with a weak pull-up, or a push-pull output that drives the data value. Software reaches the port through three byte addresses. One holds the data register, one holds the configuration register, and one is a read-only view of the pin levels after synchronization.

Parameters set the three addresses and a mask of input-only pins. Configuration writes to a masked pin are dropped, so that pin can never drive, and its configuration bit always reads back as zero. The port can also name one data bit as the halt trigger. A bus write that sets that bit sends a one-cycle halt request to the core, and the bit is still stored like any other data bit. The defaults describe a port at 0xD3/0xD5/0xD6 whose bits 6 and 7 are input-only and whose bit 7 is the halt trigger.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data and configuration registers are zero, so oe_o, out_o and pullup_en_o are all zero and halt_o is low.
- R2: The mode of bit n is {cfg[n], data[n]}. 00 gives oe=0 and pullup=0. 01 gives oe=0 and pullup=1. 10 gives oe=1 and out=0. 11 gives oe=1 and out=1. out_o[n] always equals data[n].
- R3: A write to DATA_ADDR (default 0xD3) stores wdata_i in the data register at the clock edge where wr_i is high. Pad outputs show the new value from that edge on, and a read of DATA_ADDR returns it.
- R4: A write to CFG_ADDR (default 0xD5) stores wdata_i in the configuration register. A read of CFG_ADDR returns the stored value.
- R5: A read of PIN_ADDR (default 0xD6) returns pin_i delayed by two clock edges and never the data register. Writes to PIN_ADDR change no state.
- R6: For every bit set in IN_ONLY_MASK (default 0xC0), configuration writes are ignored, oe_o stays zero and the configuration bit reads back as zero. Pull-up control still follows the data bit.
- R7: A write to DATA_ADDR with bit HALT_BIT (default 7) set makes halt_o high for exactly the one cycle after that edge. No other write raises halt_o.
- R8: rdata_o is zero when rd_i is low or when addr_i matches none of the three addresses. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Bus byte address |
| wdata_i | input | 8 | Bus write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| pin_i | input | 8 | Pad input levels |
| oe_o | output | 8 | Per-pin output enable |
| out_o | output | 8 | Per-pin output value |
| pullup_en_o | output | 8 | Per-pin weak pull-up enable |
| halt_o | output | 1 | One-cycle halt request |

## Verification
A register write takes effect at the clock edge that samples it. From that edge on, the pad outputs and register reads show the new value, and halt_o is high for the cycle that follows. A pin level shows up at the pin-read address after two edges. The bench drives inputs and compares outputs only at falling edges. Its reference model steps at each rising edge with those same latencies, so every compare falls in the middle of a cycle in which the expected value is already settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PM_HIZ    = 2'b00,
    PM_PULLUP = 2'b01,
    PM_DRV0   = 2'b10,
    PM_DRV1   = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int          WIDTH        = 8,
  parameter int          ADDR_W       = 8,
  parameter logic [7:0]  DATA_ADDR    = 8'hD3,
  parameter logic [7:0]  CFG_ADDR     = 8'hD5,
  parameter logic [WIDTH-1:0] IN_ONLY_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              wr_i,
  output logic [WIDTH-1:0]  data_q_o,
  output logic [WIDTH-1:0]  cfg_q_o
);
  localparam logic [WIDTH-1:0] CfgKeep = ~IN_ONLY_MASK;

  logic wr_data, wr_cfg;
  assign wr_data = wr_i && (addr_i == ADDR_W'(DATA_ADDR));
  assign wr_cfg  = wr_i && (addr_i == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      cfg_q_o  <= '0;
    end else begin
      if (wr_data) data_q_o <= wdata_i;
      // input-only bits never latch a config one
      if (wr_cfg)  cfg_q_o  <= wdata_i & CfgKeep;
    end
  end

  a_r3_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> data_q_o == $past(wdata_i));
  a_r4_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(cfg_q_o));
  a_r6_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q_o & IN_ONLY_MASK) == '0);
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_halt.sv
module gpio_halt #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DATA_ADDR = 8'hD3,
  parameter bit         HALT_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              trig_bit_i,
  output logic              halt_o
);
  generate
    if (HALT_EN) begin : g_halt
      logic halt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) halt_q <= 1'b0;
        else         halt_q <= wr_i && trig_bit_i && (addr_i == ADDR_W'(DATA_ADDR));
      end
      assign halt_o = halt_q;

      a_r7_halt_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && trig_bit_i && addr_i == ADDR_W'(DATA_ADDR)) |=> halt_o);
      a_r7_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && trig_bit_i && addr_i == ADDR_W'(DATA_ADDR)) |=> !halt_o);
    end else begin : g_no_halt
      assign halt_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] cfg_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] pullup_en_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    pin_mode_e mode;
    assign mode = pin_mode_e'({cfg_i[i], data_i[i]});
    always_comb begin
      oe_o[i]        = 1'b0;
      pullup_en_o[i] = 1'b0;
      unique case (mode)
        PM_HIZ:    ;
        PM_PULLUP: pullup_en_o[i] = 1'b1;
        PM_DRV0,
        PM_DRV1:   oe_o[i] = 1'b1;
        default:   ;
      endcase
    end
    assign out_o[i] = data_i[i];
  end

  always_comb begin
    a_r2_no_pull_when_drive: assert ((oe_o & pullup_en_o) == '0);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int         WIDTH        = 8,
  parameter int         ADDR_W       = 8,
  parameter logic [7:0] DATA_ADDR    = 8'hD3,
  parameter logic [7:0] CFG_ADDR     = 8'hD5,
  parameter logic [7:0] PIN_ADDR     = 8'hD6,
  parameter logic [WIDTH-1:0] IN_ONLY_MASK = 8'hC0,
  parameter bit         HALT_EN      = 1'b1,
  parameter int         HALT_BIT     = 7,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  oe_o,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  pullup_en_o,
  output logic              halt_o
);
  logic [WIDTH-1:0] data_q, cfg_q, pin_sync;

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
    .CFG_ADDR(CFG_ADDR), .IN_ONLY_MASK(IN_ONLY_MASK)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .data_q_o(data_q), .cfg_q_o(cfg_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_halt #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .HALT_EN(HALT_EN)) i_halt (
    .clk_i, .rst_ni, .addr_i, .wr_i,
    .trig_bit_i(wdata_i[HALT_BIT]), .halt_o
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) i_pad (
    .data_i(data_q), .cfg_i(cfg_q),
    .oe_o, .out_o, .pullup_en_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if      (addr_i == ADDR_W'(DATA_ADDR)) rdata_o = data_q;
      else if (addr_i == ADDR_W'(CFG_ADDR))  rdata_o = cfg_q;
      else if (addr_i == ADDR_W'(PIN_ADDR))  rdata_o = pin_sync;
    end
  end

  a_r6_in_only_never_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o & IN_ONLY_MASK) == '0);
  a_r7_halt_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> !halt_o || $past(wr_i && addr_i == ADDR_W'(DATA_ADDR)));
  a_r5_pin_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(PIN_ADDR)) |=> $stable(data_q) && $stable(cfg_q));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam logic [7:0] A_DATA = 8'hD3, A_CFG = 8'hD5, A_PIN = 8'hD6;
  localparam logic [7:0] MASK = 8'hC0;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, pin = 0;
  logic wr = 0, rd = 0;
  logic [7:0] rdata, oe, out, pu;
  logic halt;

  always #10 clk = ~clk;

  gpio_port i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .pin_i(pin), .oe_o(oe), .out_o(out),
    .pullup_en_o(pu), .halt_o(halt)
  );

  // behavioural reference
  logic [7:0] m_data, m_cfg;
  logic [7:0] m_pipe[$];
  logic m_halt;
  int vecs = 0, errs = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_cfg = 0; m_halt = 0;
      m_pipe = '{8'h00, 8'h00};
    end else begin
      m_halt = wr && addr == A_DATA && wdata[7];
      m_pipe.push_back(pin);
      void'(m_pipe.pop_front());
      if (wr && addr == A_DATA) m_data = wdata;
      if (wr && addr == A_CFG)  m_cfg  = wdata & ~MASK;
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!rd) return 8'h00;
    if (addr == A_DATA) return m_data;
    if (addr == A_CFG)  return m_cfg;
    if (addr == A_PIN)  return m_pipe[0];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 oe", oe, m_cfg);
    chk("R2 out", out, m_data);
    chk("R2 pullup", pu, ~m_cfg & m_data);
    chk("R6 oe masked", oe & MASK, 8'h00);
    chk("R7 halt", {7'd0, halt}, {7'd0, m_halt});
    chk("R3/R4/R5/R8 rdata", rdata, exp_rdata());
  endtask

  task automatic cyc(logic w, logic r, logic [7:0] a, logic [7:0] d, logic [7:0] p);
    @(negedge clk);
    compare();
    wr = w; rd = r; addr = a; wdata = d; pin = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", oe, 8'h00);
    chk("R1 pullup", pu, 8'h00);
    chk("R1 halt", {7'd0, halt}, 8'h00);
    rst_n = 1;
    // R2: all four modes on low nibble
    cyc(1, 0, A_DATA, 8'h0A, 8'h00);
    cyc(1, 0, A_CFG,  8'h0C, 8'h00);
    cyc(0, 1, A_DATA, 8'h00, 8'h00);
    cyc(0, 1, A_CFG,  8'h00, 8'h00);
    // R6: config all ones, masked bits stay zero
    cyc(1, 0, A_CFG, 8'hFF, 8'h00);
    cyc(0, 1, A_CFG, 8'h00, 8'h00);
    // R7: halt via bit 7, then a bit-7-clear write, then bit 7 to cfg address
    cyc(1, 0, A_DATA, 8'h80, 8'h00);
    cyc(0, 1, A_DATA, 8'h00, 8'h00);
    cyc(1, 0, A_DATA, 8'h7F, 8'h00);
    cyc(1, 0, A_CFG,  8'h80, 8'h00);
    cyc(1, 0, A_DATA, 8'hC0, 8'h00);
    cyc(1, 0, A_DATA, 8'h80, 8'h00);
    cyc(0, 0, A_DATA, 8'h00, 8'h00);
    // R5: pin path and write-ignore
    cyc(0, 1, A_PIN, 8'h00, 8'hA5);
    cyc(0, 1, A_PIN, 8'h00, 8'h5A);
    cyc(1, 1, A_PIN, 8'hFF, 8'h5A);
    cyc(0, 1, A_PIN, 8'h00, 8'h5A);
    cyc(0, 1, A_DATA, 8'h00, 8'h5A);
    // R8: unmapped read and write, rd low
    cyc(1, 1, 8'hD4, 8'hFF, 8'h00);
    cyc(0, 1, 8'hD0, 8'h00, 8'h00);
    cyc(0, 0, A_CFG, 8'h00, 8'h00);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = A_DATA;
        1: a = A_CFG;
        2: a = A_PIN;
        3: a = 8'($urandom);
        default: a = A_DATA;
      endcase
      cyc(1'($urandom), 1'($urandom), a, 8'($urandom), 8'($urandom));
    end
    cyc(0, 0, 8'h00, 8'h00, 8'h00);
    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 oe after reset", oe, 8'h00);
    chk("R1 out after reset", out, 8'h00);
    chk("R1 halt after reset", {7'd0, halt}, 8'h00);
    finish_run();
  end
endmodule